// File: doc/BRIEF.md
# Hysteretic Decimation-Scale Selector with Master/Slave Sharing

This block turns a measured input-to-output sample-rate ratio into a small quantized step. The step sets how far the decimation filter length is stretched. Each new ratio arrives with a one-cycle valid strobe. The step moves only when the ratio clears a step boundary by a fixed margin, and it moves by at most one step per strobe. A ratio that wanders close to a boundary therefore cannot make the filter length flip back and forth.

When several converters run from the same port clocks, one of them acts as master. The master drives its step onto a sharing bus, with a one-cycle valid pulse for each update. The others run as slaves. A slave ignores its own ratio measurements and copies the shared step, so every converter uses the same scale and has the same group delay.

The control is a three-state machine:
- ACQUIRE is the state after reset, and no step is valid in it.
- TRACK is the master's hysteretic mode.
- FOLLOW is the slave's copying mode.

The transitions are:
- ACQUIRE→TRACK on the first ratio strobe in master mode.
- ACQUIRE→FOLLOW on the first shared strobe in slave mode.
- TRACK→FOLLOW whenever master mode is dropped.
- FOLLOW→ACQUIRE whenever master mode is raised.

Top module: `ratio_scale_hyst`

## Requirements
- R1: While reset is asserted, and right after it is released, scale_out is 0, scale_vld is 0 and share_out_vld is 0.
- R2: In ACQUIRE with is_master high, a ratio_vld strobe loads scale_out with floor(ratio_in/STEP_SIZE), capped at NUM_STEPS-1, with no hysteresis. This step is visible with scale_vld high after that clock edge. The defaults are STEP_SIZE=256, MARGIN=32 and NUM_STEPS=6, so steps run from 0 to 5.
- R3: In TRACK with current step s < NUM_STEPS-1, a strobe with ratio_in >= (s+1)*STEP_SIZE+MARGIN raises the step to s+1.
- R4: In TRACK with current step s > 0, a strobe with ratio_in < s*STEP_SIZE-MARGIN lowers the step to s-1.
- R5: In TRACK, a strobe whose ratio meets neither condition of R3 or R4 leaves the step unchanged. This includes the top step and step 0.
- R6: In TRACK, the step changes by at most one per strobe, however far the ratio lies from the current step.
- R7: Without a ratio_vld strobe or a share_in_vld strobe, scale_out does not change.
- R8: Each strobe processed in master mode gives a one-cycle share_out_vld pulse. The pulse appears in the same cycle as the updated scale_out, and share_out equals that step. share_out_vld is low in every other cycle.
- R9: With is_master low, a share_in_vld strobe loads scale_out from share_in, clamped to NUM_STEPS-1. In this mode ratio strobes have no effect and share_out_vld stays low.
- R10: Dropping is_master while in TRACK keeps the current step and keeps scale_vld high until a shared strobe arrives.
- R11: Raising is_master while in FOLLOW returns the block to ACQUIRE. scale_vld falls and scale_out holds its value, and the next ratio strobe is handled as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | 1 = master (uses own ratio), 0 = slave (copies shared step) |
| ratio_in | input | RATIO_W | Measured rate ratio, unsigned fixed point |
| ratio_vld | input | 1 | One-cycle strobe qualifying ratio_in |
| share_in | input | STEP_W | Step received from the master |
| share_in_vld | input | 1 | Strobe qualifying share_in |
| scale_out | output | STEP_W | Current filter-length scale step |
| scale_vld | output | 1 | scale_out holds an acquired step |
| share_out | output | STEP_W | Step broadcast to slaves |
| share_out_vld | output | 1 | One-cycle pulse per master update |

## Verification
The bench probes ratios exactly on each rise threshold and each fall threshold, and one count to either side of them. A design that drops the margin, or uses > where >= is meant, would move a step early or miss the move. Large ratio jumps are used to catch a design that snaps straight to the raw step instead of moving by one. Ratios outside the step range test saturation at step 0 and step 5. Out-of-range shared values test the clamp, and ratio strobes sent to a slave test that a slave ignores its own measurement. The mode changes in both directions are checked too: a wrong design would lose the step when turned into a slave, or would apply hysteresis to the first ratio after becoming master again.

// File: rtl/srq_pkg.sv
package srq_pkg;
    typedef enum logic [1:0] {
        ST_ACQUIRE = 2'd0,
        ST_TRACK   = 2'd1,
        ST_FOLLOW  = 2'd2
    } srq_state_e;
endpackage

// File: rtl/srq_raw_step.sv
module srq_raw_step #(
    parameter int RATIO_W   = 12,
    parameter int NUM_STEPS = 6,
    parameter int STEP_SIZE = 256,
    parameter int STEP_W    = $clog2(NUM_STEPS)
) (
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [STEP_W-1:0]  step_o
);
    localparam int PAD_W = 32 - RATIO_W;

    logic [31:0]          ratio_wide;
    logic [NUM_STEPS-1:0] at_or_above;

    assign ratio_wide = {{PAD_W{1'b0}}, ratio_i};
    assign at_or_above[0] = 1'b1;

    // One comparator per step boundary; the boundaries rise with k.
    for (genvar k = 1; k < NUM_STEPS; k++) begin : g_bound
        assign at_or_above[k] = (ratio_wide >= 32'(k * STEP_SIZE));
    end

    always_comb begin
        step_o = '0;
        for (int k = 1; k < NUM_STEPS; k++) begin
            step_o = step_o + STEP_W'(at_or_above[k]);
        end
    end
endmodule

// File: rtl/srq_hyst.sv
module srq_hyst #(
    parameter int RATIO_W   = 12,
    parameter int NUM_STEPS = 6,
    parameter int STEP_SIZE = 256,
    parameter int MARGIN    = 32,
    parameter int STEP_W    = $clog2(NUM_STEPS)
) (
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic [STEP_W-1:0]  cur_i,
    output logic [STEP_W-1:0]  nxt_o,
    output logic               go_up_o,
    output logic               go_down_o
);
    localparam int PAD_W = 32 - RATIO_W;
    localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(NUM_STEPS - 1);

    logic [31:0] ratio_wide;
    logic [31:0] low_edge;
    logic [31:0] rise_thr;

    assign ratio_wide = {{PAD_W{1'b0}}, ratio_i};
    assign low_edge   = 32'(cur_i) * 32'(STEP_SIZE);
    assign rise_thr   = low_edge + 32'(STEP_SIZE) + 32'(MARGIN);

    // Falling test is moved to the ratio side so no threshold goes negative.
    assign go_up_o   = (cur_i != TOP_STEP) && (ratio_wide >= rise_thr);
    assign go_down_o = (cur_i != '0) && ((ratio_wide + 32'(MARGIN)) < low_edge);

    always_comb begin
        nxt_o = cur_i;
        if (go_up_o) begin
            nxt_o = cur_i + 1'b1;
        end else if (go_down_o) begin
            nxt_o = cur_i - 1'b1;
        end
    end

    // R5
    always_comb begin
        up_down_excl_chk: assert ($onehot0({go_up_o, go_down_o}));
    end
endmodule

// File: rtl/srq_share_rx.sv
module srq_share_rx #(
    parameter int NUM_STEPS = 6,
    parameter int STEP_W    = $clog2(NUM_STEPS)
) (
    input  logic [STEP_W-1:0] share_i,
    output logic [STEP_W-1:0] step_o
);
    localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(NUM_STEPS - 1);

    assign step_o = (share_i > TOP_STEP) ? TOP_STEP : share_i;
endmodule

// File: rtl/ratio_scale_hyst.sv
module ratio_scale_hyst
    import srq_pkg::*;
#(
    parameter int RATIO_W   = 12,
    parameter int NUM_STEPS = 6,
    parameter int STEP_SIZE = 256,
    parameter int MARGIN    = 32,
    parameter int STEP_W    = $clog2(NUM_STEPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               is_master,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               ratio_vld,
    input  logic [STEP_W-1:0]  share_in,
    input  logic               share_in_vld,
    output logic [STEP_W-1:0]  scale_out,
    output logic               scale_vld,
    output logic [STEP_W-1:0]  share_out,
    output logic               share_out_vld
);
    localparam logic [STEP_W-1:0] TOP_STEP = STEP_W'(NUM_STEPS - 1);

    srq_state_e        state_q, state_d;
    logic [STEP_W-1:0] scale_q;
    logic              bcast_q;
    logic [STEP_W-1:0] raw_step;
    logic [STEP_W-1:0] hyst_step;
    logic [STEP_W-1:0] rx_step;
    logic              hyst_up, hyst_down;

    srq_raw_step #(
        .RATIO_W(RATIO_W), .NUM_STEPS(NUM_STEPS),
        .STEP_SIZE(STEP_SIZE), .STEP_W(STEP_W)
    ) u_raw (
        .ratio_i(ratio_in),
        .step_o (raw_step)
    );

    srq_hyst #(
        .RATIO_W(RATIO_W), .NUM_STEPS(NUM_STEPS), .STEP_SIZE(STEP_SIZE),
        .MARGIN(MARGIN), .STEP_W(STEP_W)
    ) u_hyst (
        .ratio_i  (ratio_in),
        .cur_i    (scale_q),
        .nxt_o    (hyst_step),
        .go_up_o  (hyst_up),
        .go_down_o(hyst_down)
    );

    srq_share_rx #(
        .NUM_STEPS(NUM_STEPS), .STEP_W(STEP_W)
    ) u_rx (
        .share_i(share_in),
        .step_o (rx_step)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: begin
                if (is_master && ratio_vld) begin
                    state_d = ST_TRACK;
                end else if (!is_master && share_in_vld) begin
                    state_d = ST_FOLLOW;
                end
            end
            ST_TRACK: begin
                if (!is_master) begin
                    state_d = ST_FOLLOW;
                end
            end
            ST_FOLLOW: begin
                if (is_master) begin
                    state_d = ST_ACQUIRE;
                end
            end
            default: state_d = ST_ACQUIRE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACQUIRE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_q <= '0;
            bcast_q <= 1'b0;
        end else begin
            bcast_q <= 1'b0;
            unique case (state_q)
                ST_ACQUIRE: begin
                    if (is_master && ratio_vld) begin
                        scale_q <= raw_step;
                        bcast_q <= 1'b1;
                    end else if (!is_master && share_in_vld) begin
                        scale_q <= rx_step;
                    end
                end
                ST_TRACK: begin
                    if (is_master) begin
                        if (ratio_vld) begin
                            scale_q <= hyst_step;
                            bcast_q <= 1'b1;
                        end
                    end else if (share_in_vld) begin
                        scale_q <= rx_step;
                    end
                end
                ST_FOLLOW: begin
                    if (!is_master && share_in_vld) begin
                        scale_q <= rx_step;
                    end
                end
                default: scale_q <= scale_q;
            endcase
        end
    end

    assign scale_out     = scale_q;
    assign scale_vld     = (state_q != ST_ACQUIRE);
    assign share_out     = scale_q;
    assign share_out_vld = bcast_q;

    // R2
    acquire_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQUIRE && is_master && ratio_vld) |=> scale_vld);

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && is_master && ratio_vld) |=>
        (scale_out == $past(scale_out)) || (scale_out == $past(scale_out) + 1'b1) ||
        (scale_out + 1'b1 == $past(scale_out)));

    // R7
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ratio_vld && !share_in_vld) |=> $stable(scale_out));

    // R8
    slave_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |=> !share_out_vld);

    // R9
    slave_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !share_in_vld) |=> $stable(scale_out));

    // R9
    step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scale_out <= TOP_STEP);

    // R11
    reacquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOLLOW && is_master) |=> (!scale_vld && $stable(scale_out)));
endmodule

// File: tb/sim_ratio_scale_hyst.sv
`timescale 1ns/1ps
module sim_ratio_scale_hyst;
    localparam int NV = 18;
    localparam logic [11:0] V_RATIO [NV] = '{
        12'd600,  12'd800,  12'd1050, 12'd1056, 12'd1000, 12'd991,
        12'd4000, 12'd4000, 12'd4095, 12'd0,    12'd0,    12'd735,
        12'd480,  12'd479,  12'd225,  12'd223,  12'd0,    12'd287
    };
    localparam logic [2:0] V_EXP [NV] = '{
        3'd2, 3'd3, 3'd3, 3'd4, 3'd4, 3'd3,
        3'd4, 3'd5, 3'd5, 3'd4, 3'd3, 3'd2,
        3'd2, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        is_master = 1'b1;
    logic [11:0] ratio_in = '0;
    logic        ratio_vld = 1'b0;
    logic [2:0]  share_in = '0;
    logic        share_in_vld = 1'b0;
    logic [2:0]  scale_out, share_out;
    logic        scale_vld, share_out_vld;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    ratio_scale_hyst u0 (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .ratio_in(ratio_in), .ratio_vld(ratio_vld),
        .share_in(share_in), .share_in_vld(share_in_vld),
        .scale_out(scale_out), .scale_vld(scale_vld),
        .share_out(share_out), .share_out_vld(share_out_vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, return after the next falling edge.
    task automatic cyc(input logic m, input logic [11:0] r, input logic rv,
                       input logic [2:0] s, input logic sv);
        is_master = m; ratio_in = r; ratio_vld = rv; share_in = s; share_in_vld = sv;
        @(negedge clk);
        ratio_vld = 1'b0; share_in_vld = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(1'b1, 12'd0, 1'b0, 3'd0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(1'b1, 12'd900, 1'b1, 3'd4, 1'b1);
        chk("R1 scale_out in reset", scale_out, 0);
        chk("R1 scale_vld in reset", scale_vld, 0);
        chk("R1 share_out_vld in reset", share_out_vld, 0);
        rst_n = 1'b1;
        cyc(1'b1, 12'd0, 1'b0, 3'd0, 1'b0);
        chk("R1 scale_vld after reset", scale_vld, 0);

        // Master tracking table: R2 first entry, then R3/R4/R5/R6
        for (int i = 0; i < NV; i++) begin
            cyc(1'b1, V_RATIO[i], 1'b1, 3'd0, 1'b0);
            chk($sformatf("R3/R4/R5/R6 vec%0d scale", i), scale_out, V_EXP[i]);
            chk($sformatf("R8 vec%0d share_out_vld", i), share_out_vld, 1);
            chk($sformatf("R8 vec%0d share_out", i), share_out, V_EXP[i]);
            chk($sformatf("R2 vec%0d scale_vld", i), scale_vld, 1);
        end

        // R7: ratio changes without strobe
        cyc(1'b1, 12'd4095, 1'b0, 3'd0, 1'b0);
        cyc(1'b1, 12'd4095, 1'b0, 3'd0, 1'b0);
        chk("R7 hold without strobe", scale_out, 0);
        chk("R8 no pulse without strobe", share_out_vld, 0);

        // R10: become slave, value kept
        cyc(1'b1, 12'd600, 1'b1, 3'd0, 1'b0);
        chk("R3 rise from 0 at 600", scale_out, 1);
        cyc(1'b0, 12'd0, 1'b0, 3'd0, 1'b0);
        cyc(1'b0, 12'd0, 1'b0, 3'd0, 1'b0);
        chk("R10 step kept as slave", scale_out, 1);
        chk("R10 valid kept as slave", scale_vld, 1);

        // R9: ratio ignored in slave, shared adopted and clamped
        cyc(1'b0, 12'd4095, 1'b1, 3'd0, 1'b0);
        chk("R9 ratio ignored in slave", scale_out, 1);
        chk("R9 no broadcast in slave", share_out_vld, 0);
        cyc(1'b0, 12'd0, 1'b0, 3'd3, 1'b1);
        chk("R9 adopt shared 3", scale_out, 3);
        cyc(1'b0, 12'd0, 1'b0, 3'd7, 1'b1);
        chk("R9 clamp shared 7", scale_out, 5);
        cyc(1'b0, 12'd0, 1'b0, 3'd0, 1'b1);
        chk("R9 adopt shared 0 (large drop)", scale_out, 0);
        cyc(1'b0, 12'd0, 1'b0, 3'd6, 1'b1);
        chk("R9 clamp shared 6", scale_out, 5);
        repeat (3) cyc(1'b0, 12'd0, 1'b0, 3'd1, 1'b0);
        chk("R10 slave holds without strobe", scale_out, 5);

        // R11: back to master, reacquire without hysteresis
        cyc(1'b1, 12'd0, 1'b0, 3'd0, 1'b0);
        chk("R11 valid drops", scale_vld, 0);
        chk("R11 value held", scale_out, 5);
        cyc(1'b1, 12'd300, 1'b1, 3'd0, 1'b0);
        chk("R11 reacquire raw step", scale_out, 1);
        chk("R11 valid again", scale_vld, 1);
        chk("R8 pulse on reacquire", share_out_vld, 1);

        // R2: cap on first acquisition
        do_reset();
        cyc(1'b1, 12'd4095, 1'b1, 3'd0, 1'b0);
        chk("R2 raw step capped", scale_out, 5);
        cyc(1'b1, 12'd1279, 1'b1, 3'd0, 1'b0);
        chk("R5 top step dead band", scale_out, 5);
        cyc(1'b1, 12'd1247, 1'b1, 3'd0, 1'b0);
        chk("R4 fall from top", scale_out, 4);

        // R2: edge of raw boundary; slave acquisition from reset
        do_reset();
        cyc(1'b1, 12'd767, 1'b1, 3'd0, 1'b0);
        chk("R2 raw just below boundary", scale_out, 2);
        do_reset();
        cyc(1'b0, 12'd900, 1'b1, 3'd0, 1'b0);
        chk("R9 slave acquire ignores ratio", scale_vld, 0);
        cyc(1'b0, 12'd0, 1'b0, 3'd2, 1'b1);
        chk("R9 slave acquire shared", scale_out, 2);
        chk("R9 slave acquire valid", scale_vld, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule